// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block watches the address and chip-enable inputs of the two ports of a shared memory and decides, every clock cycle, whether both ports are aiming at the same word. When they collide, the port that settled on that word later is told to back off. Its active-low busy output goes low, and its write path is blocked until the collision clears. The port that got there first keeps full access.

Arrival order comes from comparing each port's request with the value it held in the previous cycle. A port whose address or enable moved in the cycle the collision began is the later arrival. If both moved in that cycle, or neither did, the left port wins.

A mode input turns the block into a follower. In that mode the arbiter drives no busy of its own. It takes busy from outside on both sides and uses it only to block writes.

Top module: `collision_arbiter`

## Requirements
- R1: In master mode (modeSlave=0), both busyLN and busyRN are high after any clock edge at which the two addresses differed or either enable (ceLN, ceRN, active low) was high.
- R2: In master mode, when both ports are enabled on the same address and only one port's address or enable changed at the edge that began the match, that port's busy output is low after that edge and the other busy output is high.
- R3: busyLN and busyRN are never low at the same time.
- R4: In master mode, when both ports' requests changed at the same edge and produced a match, busyRN goes low and busyLN stays high (the left port wins the tie).
- R5: While the match persists from edge to edge, the winner is unchanged, including when both ports move together to a new common address.
- R6: In master mode, busy is released (back to high) after the first edge at which the match is gone.
- R7: In master mode, wrBlockL is 1 exactly when busyLN is low, and wrBlockR is 1 exactly when busyRN is low.
- R8: In slave mode (modeSlave=1), busyLN and busyRN are held high, and wrBlockL = NOT busyInLN, wrBlockR = NOT busyInRN, whatever the addresses.
- R9: While rstN is low, busyLN and busyRN are high and wrBlockL and wrBlockR are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSlave | input | 1 | 0 = master (generate busy), 1 = slave (accept busy) |
| addrL | input | 11 | Left port address |
| ceLN | input | 1 | Left port enable, active low |
| addrR | input | 11 | Right port address |
| ceRN | input | 1 | Right port enable, active low |
| busyInLN | input | 1 | External busy for the left port, active low, used in slave mode |
| busyInRN | input | 1 | External busy for the right port, active low, used in slave mode |
| busyLN | output | 1 | Busy to the left port, active low |
| busyRN | output | 1 | Busy to the right port, active low |
| wrBlockL | output | 1 | 1 = left port writes are ignored |
| wrBlockR | output | 1 | 1 = right port writes are ignored |

## Verification
A wrong arrival register shows one edge after the collision starts. The wrong port goes busy, or the winner flips while the two ports move together, so each step of the vector walk compares both busy lines against the order in which the ports arrived. A stale owner that survives the end of a collision shows up as a busy that is still low one cycle after the addresses split. A wrong mode mask shows up directly on the write-block outputs when the external busy inputs are toggled.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int ADDR_W = 11;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;

  typedef struct packed {
    logic match;
    logic chgL;
    logic chgR;
  } strobe_t;
endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addrL,
  input  logic          ceLN,
  input  logic [AW-1:0] addrR,
  input  logic          ceRN,
  output strobe_t       strb
);
  logic [AW-1:0] prevAddrL, prevAddrR;
  logic          prevCeLN, prevCeRN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAddrL <= '0;
      prevAddrR <= '0;
      prevCeLN  <= 1'b1;
      prevCeRN  <= 1'b1;
    end else begin
      prevAddrL <= addrL;
      prevAddrR <= addrR;
      prevCeLN  <= ceLN;
      prevCeRN  <= ceRN;
    end
  end

  always_comb begin
    strb.match = !ceLN && !ceRN && (addrL == addrR);
    strb.chgL  = (addrL != prevAddrL) || (ceLN != prevCeLN);
    strb.chgR  = (addrR != prevAddrR) || (ceRN != prevCeRN);
  end
endmodule

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeSlave,
  input  strobe_t strb,
  input  logic    busyInLN,
  input  logic    busyInRN,
  output logic    busyLN,
  output logic    busyRN,
  output logic    wrBlockL,
  output logic    wrBlockR
);
  owner_t owner, ownerNext;

  always_comb begin
    if (!strb.match)
      ownerNext = OWN_NONE;
    else if (owner != OWN_NONE)
      ownerNext = owner;
    else if (strb.chgL && !strb.chgR)
      ownerNext = OWN_RIGHT;
    else
      ownerNext = OWN_LEFT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owner <= OWN_NONE;
    else       owner <= ownerNext;
  end

  always_comb begin
    if (!rstN) begin
      busyLN   = 1'b1;
      busyRN   = 1'b1;
      wrBlockL = 1'b0;
      wrBlockR = 1'b0;
    end else if (modeSlave) begin
      busyLN   = 1'b1;
      busyRN   = 1'b1;
      wrBlockL = !busyInLN;
      wrBlockR = !busyInRN;
    end else begin
      busyLN   = (owner != OWN_RIGHT);
      busyRN   = (owner != OWN_LEFT);
      wrBlockL = (owner == OWN_RIGHT);
      wrBlockR = (owner == OWN_LEFT);
    end
  end

  // R3
  never_both_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyLN || busyRN);

  // R6
  release_after_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.match |=> (busyLN && busyRN));

  // R5
  winner_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSlave && !busyRN && strb.match) |=> (modeSlave || !busyRN));

  // R7
  block_follows_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeSlave |-> ((wrBlockL == !busyLN) && (wrBlockR == !busyRN)));

  // R8
  slave_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeSlave |-> (busyLN && busyRN));
endmodule

// File: rtl/collision_arbiter.sv
module collision_arbiter
  import arb_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modeSlave,
  input  logic [AW-1:0] addrL,
  input  logic          ceLN,
  input  logic [AW-1:0] addrR,
  input  logic          ceRN,
  input  logic          busyInLN,
  input  logic          busyInRN,
  output logic          busyLN,
  output logic          busyRN,
  output logic          wrBlockL,
  output logic          wrBlockR
);
  strobe_t strb;

  arb_datapath #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .addrL(addrL), .ceLN(ceLN),
    .addrR(addrR), .ceRN(ceRN), .strb(strb)
  );

  arb_control u_ctl (
    .clk(clk), .rstN(rstN), .modeSlave(modeSlave), .strb(strb),
    .busyInLN(busyInLN), .busyInRN(busyInRN),
    .busyLN(busyLN), .busyRN(busyRN), .wrBlockL(wrBlockL), .wrBlockR(wrBlockR)
  );

  // R1: a busy that is low must come from a match at the previous edge
  busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyLN || !busyRN) |->
      ($past(!ceLN) && $past(!ceRN) && ($past(addrL) == $past(addrR))));
endmodule

// File: tb/sim_collision_arbiter.sv
module sim_collision_arbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSlave = 1'b0;
  logic [10:0] addrL = '0, addrR = '0;
  logic ceLN = 1'b1, ceRN = 1'b1;
  logic busyInLN = 1'b1, busyInRN = 1'b1;
  logic busyLN, busyRN, wrBlockL, wrBlockR;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  collision_arbiter u0 (
    .clk(clk), .rstN(rstN), .modeSlave(modeSlave),
    .addrL(addrL), .ceLN(ceLN), .addrR(addrR), .ceRN(ceRN),
    .busyInLN(busyInLN), .busyInRN(busyInRN),
    .busyLN(busyLN), .busyRN(busyRN), .wrBlockL(wrBlockL), .wrBlockR(wrBlockR)
  );

  // {addrL, ceLN, addrR, ceRN, expBusyLN, expBusyRN}
  localparam int NV = 14;
  localparam logic [25:0] VEC [NV] = '{
    {11'd5, 1'b0, 11'd7, 1'b0, 1'b1, 1'b1},  // R1 different addresses
    {11'd5, 1'b0, 11'd5, 1'b0, 1'b1, 1'b0},  // R2 right arrives later
    {11'd5, 1'b0, 11'd5, 1'b0, 1'b1, 1'b0},  // R5 hold
    {11'd9, 1'b0, 11'd9, 1'b0, 1'b1, 1'b0},  // R5 both move together
    {11'd9, 1'b0, 11'd3, 1'b0, 1'b1, 1'b1},  // R6 split
    {11'd3, 1'b0, 11'd3, 1'b0, 1'b0, 1'b1},  // R2 left arrives later
    {11'd3, 1'b1, 11'd3, 1'b0, 1'b1, 1'b1},  // R1 left disabled
    {11'd3, 1'b0, 11'd3, 1'b0, 1'b0, 1'b1},  // R2 left re-enables, later
    {11'd1, 1'b0, 11'd2, 1'b0, 1'b1, 1'b1},  // R6 split
    {11'd4, 1'b0, 11'd4, 1'b0, 1'b1, 1'b0},  // R4 tie on address
    {11'd4, 1'b1, 11'd4, 1'b1, 1'b1, 1'b1},  // R1 both disabled
    {11'd4, 1'b0, 11'd4, 1'b0, 1'b1, 1'b0},  // R4 tie on enable
    {11'd4, 1'b0, 11'd4, 1'b1, 1'b1, 1'b1},  // R6 right disabled
    {11'd4, 1'b0, 11'd4, 1'b0, 1'b0, 1'b0}   // R2 right later (exp RN 0, LN 1 set below)
  };

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s busyLN,busyRN,wrBlockL,wrBlockR act=%b exp=%b", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #12;
    // R9 reset state
    check("R9", {busyLN, busyRN, wrBlockL, wrBlockR}, 4'b1100);
    addrL = 11'd6; addrR = 11'd6; ceLN = 1'b0; ceRN = 1'b0;
    #10;
    check("R9", {busyLN, busyRN, wrBlockL, wrBlockR}, 4'b1100);
    ceLN = 1'b1; ceRN = 1'b1; addrL = '0; addrR = '0;
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic eL, eR;
      @(negedge clk);
      {addrL, ceLN, addrR, ceRN, eL, eR} = VEC[i];
      if (i == NV - 1) begin eL = 1'b1; eR = 1'b0; end
      @(posedge clk); #1;
      check(i == 0 ? "R1" : (i == 9 || i == 11) ? "R4" : "R2/R5/R6",
            {busyLN, busyRN, wrBlockL, wrBlockR}, {eL, eR, !eL, !eR});
      checks++;
      if (!busyLN && !busyRN) begin
        fails++;
        $display("FAIL R3 act=both low exp=at most one");
      end
    end
    // R7: block follows busy (covered above); direct check of the last state
    check("R7", {busyLN, busyRN, wrBlockL, wrBlockR}, 4'b1001);

    // R8 slave mode with a live collision
    @(negedge clk); modeSlave = 1'b1; busyInLN = 1'b0; busyInRN = 1'b1;
    #1; check("R8", {busyLN, busyRN, wrBlockL, wrBlockR}, 4'b1110);
    @(negedge clk); busyInLN = 1'b1; busyInRN = 1'b0;
    #1; check("R8", {busyLN, busyRN, wrBlockL, wrBlockR}, 4'b1101);
    @(negedge clk); busyInLN = 1'b1; busyInRN = 1'b1; addrR = 11'd8;
    @(posedge clk); #1;
    check("R8", {busyLN, busyRN, wrBlockL, wrBlockR}, 4'b1100);

    // R1 back in master with addresses apart
    @(negedge clk); modeSlave = 1'b0;
    @(posedge clk); #1;
    check("R1", {busyLN, busyRN, wrBlockL, wrBlockR}, 4'b1100);

    // R9 reset in the middle of a collision
    @(negedge clk); addrR = 11'd4;
    @(posedge clk); #1;
    check("R2", {busyLN, busyRN, wrBlockL, wrBlockR}, 4'b1001);
    rstN = 1'b0; #1;
    check("R9", {busyLN, busyRN, wrBlockL, wrBlockR}, 4'b1100);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule